// File: doc/BRIEF.md
# Serial-peripheral memory slave

This block is the device side of a four-wire serial link in front of a small byte-wide storage array. It watches chip select, serial clock and serial data in. It drives a serial data out line together with an enable that tells the pad when to drive. While chip select is low, the host first sends an 8-bit command. The block decodes that command into one of six operations: arm writes, disarm writes, read status, write status, read bytes and write bytes. Byte transfers carry a 16-bit address. Only the low `AW` bits of that address select a location in a `2**AW`-byte array; `AW = 13` gives 8192 bytes, and the default is kept smaller.

A write-arm latch guards every change to the array and to the status byte. Any command that changes storage clears the latch again once its transaction closes. The host may idle the clock low or high. Data in is taken on clock rising edges, and data out changes on falling edges. All three link inputs are resynchronised into the block clock `clk`, which must run several times faster than the serial clock.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, and at any time chip select has been high for three `clk` cycles, `so_oe` is 0. The status byte after reset is 8'h00.
- R2: The first 8 bits after chip select falls are taken MSB first on serial-clock rising edges. They are decoded as 8'h06 arm, 8'h04 disarm, 8'h05 status read, 8'h01 status write, 8'h03 byte read and 8'h02 byte write.
- R3: During a read, `so` changes only in response to a serial-clock falling edge. Each read byte appears MSB first. The first bit is valid before the first rising edge of the data phase.
- R4: Arm sets the write latch and disarm clears it. The latch is visible as status bit 1.
- R5: A status read returns {stored bits 7:2, latch, 1'b0}, so bit 0 is always 0. The byte repeats for as long as chip select stays low.
- R6: A status write stores bits 7:2 of its data byte only when the latch is set. Otherwise the status is unchanged.
- R7: A byte read takes a 16-bit address, MSB first, and uses only its low AW bits. It returns successive bytes from incrementing addresses, wrapping from the last location to 0.
- R8: A byte write changes the array only while the latch is set. Only whole bytes are stored, and a trailing partial byte is dropped. Successive bytes go to incrementing addresses that wrap within the aligned 32-byte page.
- R9: When chip select rises after a byte write or status write stored at least one byte, the latch is cleared.
- R10: An unknown command leaves `so_oe` at 0 for the rest of the transaction. It changes neither the latch nor the status.
- R11: All of the above hold both with the serial clock idling low and with it idling high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock used to oversample the link |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | High while `so` must be driven onto the line |

## Verification
The assertions check four things on every cycle. The output enable stays low while chip select is high. The output bit moves only after a falling serial-clock edge. The last bit of a status byte is zero. A status change or an array write happens only with the latch set, and an array write stays inside its page. They also check that the latch drops once a storing transaction closes. Whether the right byte lands at the right address, the wrap at the end of the array, the dropped partial byte, the repeated status byte and the silence after an unknown command can only be shown by the bench. The bench keeps its own model of the array and replays the same command sequence in both clock-idle polarities.

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int AW = 11,
  parameter int PW = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe
);
  localparam int DEPTH = 1 << AW;
  localparam int SW = (AW > 8) ? AW : 8;
  localparam logic [2:0] P_OPC = 3'd0, P_ADR = 3'd1, P_RD = 3'd2, P_WR = 3'd3,
                         P_SRO = 3'd4, P_SRI = 3'd5, P_END = 3'd6;

  logic [2:0] s1, s2;
  logic sck_q;
  logic cs_s, sck_s, si_s, rise, fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 3'b100;
      s2 <= 3'b100;
      sck_q <= 1'b0;
    end else begin
      s1 <= {cs_n, sck, si};
      s2 <= s1;
      sck_q <= s2[1];
    end

  assign cs_s  = s2[2];
  assign sck_s = s2[1];
  assign si_s  = s2[0];
  assign rise  = !cs_s && sck_s && !sck_q;
  assign fall  = !cs_s && !sck_s && sck_q;

  logic [SW-2:0] sh;
  logic [SW-1:0] nxt;
  logic [2:0] phase;
  logic [3:0] cnt;
  logic [2:0] ocnt;
  logic [AW-1:0] addr;
  logic rd_cmd, wel, wrote, so_d, mem_we;
  logic [5:0] stat_hi;
  logic [7:0] status, rdata;
  logic [7:0] mem [DEPTH];

  assign nxt    = {sh, si_s};
  assign status = {stat_hi, wel, 1'b0};
  assign rdata  = mem[addr];
  assign mem_we = rise && phase == P_WR && cnt == 4'd7 && wel;
  assign so     = so_d;
  assign so_oe  = !cs_s && (phase == P_RD || phase == P_SRO);

  always_ff @(posedge clk)
    if (mem_we) mem[addr] <= nxt[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh <= '0; phase <= P_OPC; cnt <= '0; ocnt <= '0; addr <= '0;
      rd_cmd <= 1'b0; wel <= 1'b0; wrote <= 1'b0; so_d <= 1'b0; stat_hi <= '0;
    end else if (cs_s) begin
      phase <= P_OPC;
      cnt <= '0;
      ocnt <= '0;
      wrote <= 1'b0;
      if (wrote) wel <= 1'b0;
    end else begin
      if (rise) begin
        sh <= nxt[SW-2:0];
        cnt <= cnt + 4'd1;
        case (phase)
          P_OPC: if (cnt == 4'd7) begin
            cnt <= '0;
            case (nxt[7:0])
              8'h06: begin wel <= 1'b1; phase <= P_END; end
              8'h04: begin wel <= 1'b0; phase <= P_END; end
              8'h05: phase <= P_SRO;
              8'h01: phase <= P_SRI;
              8'h03: begin rd_cmd <= 1'b1; phase <= P_ADR; end
              8'h02: begin rd_cmd <= 1'b0; phase <= P_ADR; end
              default: phase <= P_END;
            endcase
          end
          P_ADR: if (cnt == 4'd15) begin
            cnt <= '0;
            addr <= nxt[AW-1:0];
            phase <= rd_cmd ? P_RD : P_WR;
          end
          P_WR: if (cnt == 4'd7) begin
            cnt <= '0;
            if (wel) begin
              addr <= {addr[AW-1:PW], addr[PW-1:0] + PW'(1)};
              wrote <= 1'b1;
            end
          end
          P_SRI: if (cnt == 4'd7) begin
            if (wel) begin
              stat_hi <= nxt[7:2];
              wrote <= 1'b1;
            end
            phase <= P_END;
          end
          default: ;
        endcase
      end
      if (fall && phase == P_RD) begin
        so_d <= rdata[~ocnt];
        ocnt <= ocnt + 3'd1;
        if (ocnt == 3'd7) addr <= addr + AW'(1);
      end
      if (fall && phase == P_SRO) begin
        so_d <= status[~ocnt];
        ocnt <= ocnt + 3'd1;
      end
    end
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk #(
  parameter int AW = 11,
  parameter int PW = 5
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic so,
  input logic so_oe,
  input logic cs_s,
  input logic fall,
  input logic wel,
  input logic wrote,
  input logic [5:0] stat_hi,
  input logic [AW-1:0] addr,
  input logic mem_we,
  input logic [2:0] phase,
  input logic [2:0] ocnt
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_oe);

  assert_out_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so) |-> $past(fall));

  assert_busy_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4 && fall && ocnt == 3'd7 && !cs_s) |=> !so);

  assert_status_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_hi != $past(stat_hi)) |-> $past(wel));

  assert_write_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wel);

  assert_page_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_we) |-> addr[AW-1:PW] == $past(addr[AW-1:PW]));

  assert_latch_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wrote) && $past(cs_s)) |-> !wel);
endmodule

bind spi_mem_slave spi_mem_slave_chk #(.AW(AW), .PW(PW)) chk_i (.*);

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb_top;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam int H = 5;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe;
  logic cpol = 1'b0;
  int n_cmp = 0, n_bad = 0;
  logic [7:0] mem_m [DEPTH];
  logic [5:0] st_m = '0;
  logic wel_m = 1'b0;

  always #10 clk = ~clk;

  spi_mem_slave #(.AW(AW)) dut_i (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
                                  .si(si), .so(so), .so_oe(so_oe));

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int a, input int s);
    return 8'((a * 37 + s * 91 + 13) ^ (a >> 3));
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic q, output logic oe);
    if (cpol) sck = 1'b0;
    si = b;
    wclk(H);
    q = so;
    oe = so_oe;
    sck = 1'b1;
    wclk(H);
    if (!cpol) sck = 1'b0;
  endtask

  task automatic xb(input logic [7:0] d, output logic [7:0] q, output int oe_n);
    logic b, o;
    oe_n = 0;
    for (int i = 7; i >= 0; i--) begin
      bit_x(d[i], b, o);
      q[i] = b;
      oe_n += int'(o);
    end
  endtask

  task automatic start();
    sck = cpol;
    wclk(H);
    cs_n = 1'b0;
    wclk(H);
  endtask

  task automatic stop();
    wclk(H);
    cs_n = 1'b1;
    wclk(4);
    chk("R1 idle enable", int'(so_oe), 0);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] q; int o;
    start(); xb(op, q, o); stop();
  endtask

  task automatic rdsr(input int n, input string tag);
    logic [7:0] q; int o;
    start();
    xb(8'h05, q, o);
    for (int k = 0; k < n; k++) begin
      xb(8'h00, q, o);
      chk(tag, int'(q), int'({st_m, wel_m, 1'b0}));
      chk("R5 enable", o, 8);
    end
    stop();
  endtask

  task automatic wr(input logic [15:0] a, input int n, input int s);
    logic [7:0] q; int o;
    int base;
    base = int'(a) & (DEPTH - 1);
    start();
    xb(8'h02, q, o); xb(a[15:8], q, o); xb(a[7:0], q, o);
    for (int k = 0; k < n; k++) begin
      xb(gen(base + k, s), q, o);
      if (wel_m) mem_m[(base & ~31) | ((base + k) & 31)] = gen(base + k, s);
    end
    stop();
    if (n > 0) wel_m = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input int n);
    logic [7:0] q; int o;
    int base;
    base = int'(a) & (DEPTH - 1);
    start();
    xb(8'h03, q, o); xb(a[15:8], q, o); xb(a[7:0], q, o);
    for (int k = 0; k < n; k++) begin
      xb(8'h00, q, o);
      if (k == 0) chk("R3 first byte", int'(q), int'(mem_m[base]));
      else if (cpol) chk("R11 read idle-high", int'(q), int'(mem_m[(base + k) % DEPTH]));
      else chk("R7 read", int'(q), int'(mem_m[(base + k) % DEPTH]));
      chk("R7 enable", o, 8);
    end
    stop();
  endtask

  initial begin
    logic [7:0] q; int o, s;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    chk("R1 reset enable", int'(so_oe), 0);
    for (int m = 0; m < 2; m++) begin
      cpol = m[0];
      sck = cpol;
      wclk(8);
      s = m * 5 + 1;
      rdsr(2, "R1 status");
      cmd1(8'h06); wel_m = 1'b1;
      rdsr(1, "R2 arm");
      wr(16'hF800, 32, s);
      rdsr(1, "R9 latch drop");
      cmd1(8'h06); wel_m = 1'b1;
      wr(16'hA7E0, 32, s);
      wr(16'h0008, 4, s + 3);
      rd(16'h0008, 4);
      cmd1(8'h06); wel_m = 1'b1;
      wr(16'h001E, 4, s + 7);
      rd(16'h001C, 6);
      cmd1(8'h06); wel_m = 1'b1;
      start();
      xb(8'h02, q, o); xb(8'h00, q, o); xb(8'h05, q, o);
      xb(8'hAA ^ 8'(m), q, o);
      mem_m[5] = 8'hAA ^ 8'(m);
      for (int i = 0; i < 5; i++) begin
        logic b, oe;
        bit_x(1'b1, b, oe);
      end
      stop();
      wel_m = 1'b0;
      rd(16'h0005, 2);
      rdsr(1, "R8 partial latch");
      rd(16'h07F0, 48);
      rd(16'h0000, 32);
      start(); xb(8'h01, q, o); xb(8'hFF, q, o); stop();
      rdsr(1, "R6 ignored");
      cmd1(8'h06); wel_m = 1'b1;
      start(); xb(8'h01, q, o); xb(m ? 8'h5B : 8'hA6, q, o); stop();
      st_m = m ? 6'h16 : 6'h29;
      wel_m = 1'b0;
      rdsr(3, "R5 repeat");
      cmd1(8'h06); cmd1(8'h04);
      rdsr(1, "R4 disarm");
      cmd1(8'h06); wel_m = 1'b1;
      start();
      xb(8'hAB, q, o);
      chk("R10 silent cmd", o, 0);
      for (int k = 0; k < 3; k++) begin
        xb(8'h00, q, o);
        chk("R10 silent", o, 0);
      end
      stop();
      rdsr(1, "R10 unchanged");
      cmd1(8'h04); wel_m = 1'b0;
      rdsr(1, "R4 clear");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule